// File: doc/BRIEF.md
# Masked-Write GPIO Port Controller

This block is a register-mapped general-purpose I/O controller. Its pins are grouped into ports of 16, and `NUM_PORTS` ports are built. Each port has an output-data latch that drives the pin output values. It also has a mode latch whose bits turn the pin output drivers off (bit 1) or on (bit 0). The external pin levels are resynchronised through two flip-flops and can be read back. The block raises no interrupts.

Software reaches every latch through a 32-bit word-addressed bus. A write carries its own 16-bit pin mask in bits 31:16 and the new pin values in bits 15:0. Only the pins whose mask bit is 1 change, so any single pin can be driven or turned round without a read-modify-write sequence. The word address holds a view selector above a port index. The port index is the byte offset divided by four, because every port's register takes one 32-bit word. The selector values are 0 for output data, 1 for pin level, 2 for mode, and 3 for a reserved view. A write commits at the clock edge on which it is presented. A read returns its data combinationally in the same cycle.

Top module: `mgpio_ctrl`

## Requirements
- R1: After synchronous reset every output-data bit is 0 and every mode bit is 1. So `pin_oe` and `pin_out` are all zero, data-view reads return 0, and mode-view reads return 0x0000FFFF.
- R2: A write to view 0 of port p replaces output-data bit i with `bus_wdata[i]` only where `bus_wdata[16+i]` is 1. All other bits of that port, and all other ports, keep their values. The result is visible at `pin_out` after the write's clock edge.
- R3: A write to view 2 of port p updates mode bit i under the same mask rule. `pin_oe` bit i of that port equals the inverse of its mode bit, so 1 means driven.
- R4: A read of view 0 or view 2 returns the latch contents in bits 15:0 and zero in bits 31:16.
- R5: A read of view 1 returns the port's 16 pin levels in bits 15:0 with zero above. A change on `pin_in` appears in this read two clock edges after it is applied, and not after one edge.
- R6: Output data can be written while the pins are inputs. `pin_out` carries the value at once, and `pin_oe` stays 0 until the mode bits are cleared.
- R7: An access whose port index is NUM_PORTS or more reads as zero in every view. As a write it changes no latch.
- R8: Writes to view 1 and view 3 change no latch, and view 3 always reads as zero.
- R9: The word address is {view[1:0], port index[SLOT_BITS-1:0]}. Pin i of port p is bit 16*p+i of `pin_in`, `pin_out` and `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | SLOT_BITS+2 | Word address {view, port} |
| bus_wdata | input | 32 | Mask in 31:16, values in 15:0 |
| bus_rdata | output | 32 | Read data, zero when not reading |
| pin_in | input | 16*NUM_PORTS | External pin levels |
| pin_out | output | 16*NUM_PORTS | Per-pin output value |
| pin_oe | output | 16*NUM_PORTS | Per-pin output enable |

## Verification
A masked write commits on the edge where it is presented. The bench drives each access at a falling edge and checks `pin_out`, `pin_oe` and the readback at the next falling edge, one register stage later. Reads are combinational, so each read is sampled 1 ns after its address settles within the same low phase. For pin levels the bench changes `pin_in` at a falling edge. It then checks that the old value still reads after one rising edge and that the new value reads after the second.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;
    localparam int PORT_PINS = 16;
    localparam int WORD_W    = 32;

    typedef logic [PORT_PINS-1:0] pin_vec_t;

    typedef enum logic [1:0] {
        VIEW_DATA  = 2'd0,
        VIEW_LEVEL = 2'd1,
        VIEW_MODE  = 2'd2,
        VIEW_RSVD  = 2'd3
    } view_e;

    typedef struct packed {
        pin_vec_t mask;
        pin_vec_t value;
    } mwrite_t;

    function automatic pin_vec_t apply_mask(pin_vec_t cur, mwrite_t w);
        return (cur & ~w.mask) | (w.value & w.mask);
    endfunction

    function automatic logic [WORD_W-1:0] pack_read(pin_vec_t v);
        return {{(WORD_W-PORT_PINS){1'b0}}, v};
    endfunction
endpackage

// File: rtl/mgpio_decode.sv
module mgpio_decode
    import mgpio_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int SLOT_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel,
    input  logic                 wr,
    input  logic [SLOT_BITS+1:0] addr,
    output logic [NUM_PORTS-1:0] data_we,
    output logic [NUM_PORTS-1:0] mode_we,
    output logic [SLOT_BITS-1:0] port_idx,
    output view_e                view,
    output logic                 in_range
);
    assign port_idx = addr[SLOT_BITS-1:0];
    assign view     = view_e'(addr[SLOT_BITS+1:SLOT_BITS]);
    assign in_range = int'(port_idx) < NUM_PORTS;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_we
        logic hit;
        assign hit        = sel && wr && (int'(port_idx) == p);
        assign data_we[p] = hit && (view == VIEW_DATA);
        assign mode_we[p] = hit && (view == VIEW_MODE);
    end

    // R9: one write reaches at most one latch
    assert_one_target_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({data_we, mode_we}));
    // R7: out-of-range write strobes nothing
    assert_oob_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && !in_range) |-> (data_we == '0 && mode_we == '0));
endmodule

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
    parameter int WIDTH = 80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;
    logic             warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
            warm   <= 1'b0;
        end else begin
            stage1 <= d;
            q      <= stage1;
            warm   <= 1'b1;
        end
    end

    // R5: two flops in series between pin and register view
    assert_first_stage_R5: assert property (@(posedge clk) disable iff (rst)
        warm |-> (stage1 == $past(d)));
    assert_second_stage_R5: assert property (@(posedge clk) disable iff (rst)
        warm |-> (q == $past(stage1)));
endmodule

// File: rtl/mgpio_port_bank.sv
module mgpio_port_bank
    import mgpio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     data_we,
    input  logic     mode_we,
    input  mwrite_t  wr,
    output pin_vec_t data_q,
    output pin_vec_t mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            mode_q <= '1;
        end else begin
            if (data_we) data_q <= apply_mask(data_q, wr);
            if (mode_we) mode_q <= apply_mask(mode_q, wr);
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (data_q == '0 && mode_q == '1));
    assert_data_masked_R2: assert property (@(posedge clk) disable iff (rst)
        data_we |=> (((data_q ^ $past(data_q)) & ~$past(wr.mask)) == '0) &&
                    (((data_q ^ $past(wr.value)) & $past(wr.mask)) == '0));
    assert_data_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !data_we |=> $stable(data_q));
    assert_mode_masked_R3: assert property (@(posedge clk) disable iff (rst)
        mode_we |=> (((mode_q ^ $past(mode_q)) & ~$past(wr.mask)) == '0) &&
                    (((mode_q ^ $past(wr.value)) & $past(wr.mask)) == '0));
    assert_mode_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !mode_we |=> $stable(mode_q));
endmodule

// File: rtl/mgpio_ctrl.sv
module mgpio_ctrl
    import mgpio_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int SLOT_BITS = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic [SLOT_BITS+1:0]           bus_addr,
    input  logic [31:0]                    bus_wdata,
    output logic [31:0]                    bus_rdata,
    input  logic [NUM_PORTS*PORT_PINS-1:0] pin_in,
    output logic [NUM_PORTS*PORT_PINS-1:0] pin_out,
    output logic [NUM_PORTS*PORT_PINS-1:0] pin_oe
);
    localparam int ALL_PINS = NUM_PORTS * PORT_PINS;

    logic [NUM_PORTS-1:0] data_we, mode_we;
    logic [SLOT_BITS-1:0] port_idx;
    view_e                view;
    logic                 in_range;
    mwrite_t              wr_word;
    pin_vec_t             data_q [NUM_PORTS];
    pin_vec_t             mode_q [NUM_PORTS];
    logic [ALL_PINS-1:0]  level_q;

    assign wr_word = mwrite_t'(bus_wdata);

    mgpio_decode #(.NUM_PORTS(NUM_PORTS), .SLOT_BITS(SLOT_BITS)) u_dec (
        .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .data_we(data_we), .mode_we(mode_we), .port_idx(port_idx),
        .view(view), .in_range(in_range)
    );

    mgpio_sync #(.WIDTH(ALL_PINS)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(level_q)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        mgpio_port_bank u_bank (
            .clk(clk), .rst(rst),
            .data_we(data_we[p]), .mode_we(mode_we[p]), .wr(wr_word),
            .data_q(data_q[p]), .mode_q(mode_q[p])
        );
        assign pin_out[p*PORT_PINS +: PORT_PINS] = data_q[p];
        assign pin_oe [p*PORT_PINS +: PORT_PINS] = ~mode_q[p];
    end

    always_comb begin
        pin_vec_t sel_v;
        sel_v = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (int'(port_idx) == p) begin
                case (view)
                    VIEW_DATA:  sel_v = data_q[p];
                    VIEW_LEVEL: sel_v = level_q[p*PORT_PINS +: PORT_PINS];
                    VIEW_MODE:  sel_v = mode_q[p];
                    default:    sel_v = '0;
                endcase
            end
        end
        bus_rdata = (bus_sel && !bus_wr && in_range) ? pack_read(sel_v) : '0;
    end

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[31:16] == '0);
    assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr[SLOT_BITS+1:SLOT_BITS] == 2'd3) |-> bus_rdata == '0);
    assert_oob_read_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && int'(bus_addr[SLOT_BITS-1:0]) >= NUM_PORTS) |-> bus_rdata == '0);
endmodule

// File: tb/tb_mgpio_ctrl.sv
module tb_mgpio_ctrl;
    localparam int NP  = 5;
    localparam int SB  = 3;
    localparam int W   = NP * 16;

    logic          clk = 0;
    logic          rst = 1;
    logic          bus_sel = 0, bus_wr = 0;
    logic [SB+1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [W-1:0]  pin_in = '0, pin_out, pin_oe;

    int checks = 0, fails = 0;
    logic [15:0] md [NP];
    logic [15:0] mm [NP];

    always #4 clk = ~clk;

    mgpio_ctrl #(.NUM_PORTS(NP), .SLOT_BITS(SB)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [SB+1:0] ad(int view, int port);
        return {view[1:0], port[SB-1:0]};
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [SB+1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [SB+1:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    function automatic logic [W-1:0] exp_out();
        logic [W-1:0] v;
        for (int p = 0; p < NP; p++) v[p*16 +: 16] = md[p];
        return v;
    endfunction

    function automatic logic [W-1:0] exp_oe();
        logic [W-1:0] v;
        for (int p = 0; p < NP; p++) v[p*16 +: 16] = ~mm[p];
        return v;
    endfunction

    task automatic check_all(string req);
        logic [31:0] r;
        chk(req, pin_out, exp_out());
        chk(req, pin_oe, exp_oe());
        for (int p = 0; p < NP; p++) begin
            rd(ad(0, p), r); chk(req, W'(r), W'({16'h0, md[p]}));
            rd(ad(2, p), r); chk(req, W'(r), W'({16'h0, mm[p]}));
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #800000;
        checks++; fails++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [15:0] mk, vl;
        for (int p = 0; p < NP; p++) begin md[p] = 16'h0; mm[p] = 16'hFFFF; end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1 pin_oe", pin_oe, '0);
        chk("R1 pin_out", pin_out, '0);
        check_all("R1");

        // R2 R4 R9: masked data writes per port
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < 4; k++) begin
                mk = 16'hA5C3 ^ 16'((p + 1) * 16'h1357) ^ 16'(k * 16'h0F0F);
                vl = 16'h6B2D + 16'(p * 16'h0911) + 16'(k * 16'h3C01);
                wr(ad(0, p), {mk, vl});
                md[p] = (md[p] & ~mk) | (vl & mk);
                check_all("R2/R4/R9 data");
            end
        end
        // R3: masked mode writes
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < 3; k++) begin
                mk = 16'h3E71 ^ 16'(p * 16'h2222) ^ 16'(k * 16'h8421);
                vl = 16'hC0DE ^ 16'(k * 16'h1111) ^ 16'(p * 16'h0707);
                wr(ad(2, p), {mk, vl});
                mm[p] = (mm[p] & ~mk) | (vl & mk);
                check_all("R3 mode");
            end
        end
        // R6: data preset while pins are inputs
        wr(ad(2, 1), 32'hFFFF_FFFF); mm[1] = 16'hFFFF;
        wr(ad(0, 1), 32'hFFFF_3C3C); md[1] = 16'h3C3C;
        chk("R6 oe off", W'(pin_oe[16 +: 16]), W'(16'h0000));
        chk("R6 out preset", W'(pin_out[16 +: 16]), W'(16'h3C3C));
        wr(ad(2, 1), 32'hFFFF_0000); mm[1] = 16'h0000;
        chk("R6 oe on", W'(pin_oe[16 +: 16]), W'(16'hFFFF));
        check_all("R6");

        // R5: two-edge pin level delay
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] old_in, new_in;
            old_in = pin_in;
            for (int p = 0; p < NP; p++) new_in[p*16 +: 16] = 16'h1F2E ^ 16'((k + 1) * 16'h4B5A) ^ 16'(p * 16'h0101);
            @(negedge clk);
            pin_in = new_in;
            @(negedge clk);
            rd(ad(1, 0), r); chk("R5 one edge", W'(r), W'({16'h0, old_in[15:0]}));
            @(negedge clk);
            for (int p = 0; p < NP; p++) begin
                rd(ad(1, p), r); chk("R5 two edges", W'(r), W'({16'h0, new_in[p*16 +: 16]}));
            end
        end

        // R7: out-of-range slots
        for (int p = NP; p < (1 << SB); p++) begin
            wr(ad(0, p), 32'hFFFF_A5A5);
            wr(ad(2, p), 32'hFFFF_0000);
            for (int v = 0; v < 4; v++) begin
                rd(ad(v, p), r); chk("R7 read zero", W'(r), '0);
            end
        end
        check_all("R7 no change");

        // R8: level and reserved views ignore writes
        wr(ad(1, 2), 32'hFFFF_1234);
        wr(ad(3, 2), 32'hFFFF_5678);
        check_all("R8 no change");
        for (int p = 0; p < NP; p++) begin
            rd(ad(3, p), r); chk("R8 rsvd zero", W'(r), '0);
        end

        summary();
        $finish;
    end
endmodule